// File: doc/BRIEF.md
# Six-Decade BCD Up/Down Counter

This block is a six-digit binary-coded-decimal event counter. An external count strobe is brought into the system clock domain, and each rising edge of it moves the counter one step up or down. An inhibit input masks count edges. An asynchronous clear zeroes the decades. An output latch either follows the counter or freezes the value last shown, and it feeds the display path. The block reports a zero flag and a carry/borrow flag. The carry flag is raised by the carry chain leaving the top digit, and it spans the high part of the count pulse that wrapped the counter.

New values are loaded one digit at a time by the display scanner. A load request arms the block. Each step of the scanner writes the BCD value on the data port into the digit it currently selects. The block disarms itself once every digit has been written. A parameter picks plain decimal counting or one of two time formats, in which two of the digits wrap modulo six.

Top module: `bcd_updown_counter6`

## Requirements
- R1: After reset, `count_bcd` and `latch_bcd` are 000000, `carry` is 0 and `loading` is 0. One clock after reset is released, `zero` is 1.
- R2: With `up_dn` high, a rising edge of `count_in` that is not inhibited adds one to the counter within three clocks. Each digit rolls from its maximum to 0 and passes a carry to the next digit. Digit 0 is the least significant and sits at bits [3:0].
- R3: With `up_dn` low, each such edge subtracts one. A digit at 0 goes to its maximum and borrows from the next digit.
- R4: A rising edge of `count_in` that is sampled while `inhibit` is high leaves the counter unchanged.
- R5: Driving `clear` high sets `count_bcd` to 000000 at once, without waiting for a clock. It does not change `latch_bcd`.
- R6: While `store` is low, `latch_bcd` takes the counter value on every clock. While `store` is high, `latch_bcd` keeps the value it holds.
- R7: `carry` goes high on the count step that wraps the counter from all-maximum to 000000 when counting up, or from 000000 to all-maximum when counting down. It goes low within three clocks after `count_in` falls.
- R8: `zero` is 1 exactly when the counter has read 000000 since the last clock and no load is armed.
- R9: A one-clock `load_req` sets `loading`. Every clock with `scan_step` high writes `load_data` into the digit numbered by `scan_digit`, where 0 is the least significant and 5 the most significant. `loading` clears on the clock that writes the last of the six digits.
- R10: A load value that is not below the modulus of its digit is written as 0.
- R11: With MODE 0 every digit counts modulo ten. With MODE 1, digits 1 and 3 count modulo six, so the largest value is 995959. With MODE 2, digits 3 and 5 count modulo six, so the largest value is 595999.
- R12: While `loading` is high, `zero` is 0 even when the counter reads 000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_in | input | 1 | Count strobe, asynchronous to clk |
| up_dn | input | 1 | 1 counts up, 0 counts down |
| inhibit | input | 1 | 1 masks count edges |
| clear | input | 1 | Asynchronous clear of the counter digits |
| store | input | 1 | 1 holds the output latch, 0 makes it follow the counter |
| load_req | input | 1 | Arms a digit-by-digit load |
| scan_step | input | 1 | Scanner strobe: the selected digit is active this clock |
| scan_digit | input | 3 | Digit currently selected by the scanner, 0 = least significant |
| load_data | input | 4 | BCD value for the selected digit |
| count_bcd | output | 24 | Counter value, six BCD digits |
| latch_bcd | output | 24 | Latched display value |
| carry | output | 1 | Wrap flag for both count directions |
| zero | output | 1 | Counter reads zero and no load is armed |
| loading | output | 1 | A load is armed |

## Verification
A decimal instance and a MODE 2 time instance receive the same stimulus. The stimulus includes up runs, down runs, and wraps across zero in both directions. A down step from zero separates a correct all-maximum value (999999 against 595999) from a decade that wraps at the wrong modulus. It also checks that carry spans only the high phase of the pulse. Inhibited pulses, a clear while the latch is holding, and a load that contains a digit above its modulus separate gating faults from datapath faults. The increment that follows the load checks that the modulo-six carries ripple into the next digit.

// File: rtl/bcd6_pkg.sv
package bcd6_pkg;

    localparam int DIGIT_W = 4;

    // Modulus of digit idx for the chosen counting format.
    // 0: all decimal; 1: digits 1 and 3 by six; 2: digits 3 and 5 by six.
    function automatic int digit_mod(input int mode, input int idx);
        if (mode == 1 && (idx == 1 || idx == 3)) return 6;
        if (mode == 2 && (idx == 3 || idx == 5)) return 6;
        return 10;
    endfunction

    typedef struct packed {
        logic s0;
        logic s1;
        logic prev;
    } sync_t;

endpackage

// File: rtl/bcd_edge_sync.sv
module bcd_edge_sync
    import bcd6_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s0   = din;
        st_d.s1   = st_q.s0;
        st_d.prev = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s1 & ~st_q.prev;
    assign fall = ~st_q.s1 & st_q.prev;
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
    import bcd6_pkg::*;
#(
    parameter int MOD = 10
) (
    input  logic [DIGIT_W-1:0] cur_q,
    input  logic               up,
    input  logic               en,
    input  logic [DIGIT_W-1:0] ld_raw,
    output logic [DIGIT_W-1:0] nxt_d,
    output logic [DIGIT_W-1:0] ld_val,
    output logic               ripple
);
    localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(MOD - 1);

    logic at_edge;

    always_comb begin
        at_edge = up ? (cur_q == TOP) : (cur_q == '0);
        nxt_d   = cur_q;
        if (en) begin
            if (at_edge) nxt_d = up ? '0 : TOP;
            else         nxt_d = up ? cur_q + 1'b1 : cur_q - 1'b1;
        end
        ripple = en & at_edge;
        ld_val = (ld_raw <= TOP) ? ld_raw : '0;
    end
endmodule

// File: rtl/bcd_updown_counter6.sv
module bcd_updown_counter6
    import bcd6_pkg::*;
#(
    parameter int MODE = 0,
    parameter int NDIG = 6,
    parameter int SELW = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    count_in,
    input  logic                    up_dn,
    input  logic                    inhibit,
    input  logic                    clear,
    input  logic                    store,
    input  logic                    load_req,
    input  logic                    scan_step,
    input  logic [SELW-1:0]         scan_digit,
    input  logic [DIGIT_W-1:0]      load_data,
    output logic [NDIG*DIGIT_W-1:0] count_bcd,
    output logic [NDIG*DIGIT_W-1:0] latch_bcd,
    output logic                    carry,
    output logic                    zero,
    output logic                    loading
);
    localparam int CW = NDIG * DIGIT_W;

    typedef struct packed {
        logic [CW-1:0]   latch;
        logic            carry;
        logic            zero;
        logic            armed;
        logic [NDIG-1:0] done;
    } ctl_t;

    ctl_t            ctl_d, ctl_q;
    logic [CW-1:0]   cnt_d, cnt_q;
    logic [CW-1:0]   cnt_step, ld_vals, max_val;
    logic [NDIG:0]   chain;
    logic            c_rise, c_fall, step, load_hit;

    bcd_edge_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (count_in),
        .rise (c_rise),
        .fall (c_fall)
    );

    assign step     = c_rise & ~inhibit;
    assign chain[0] = step;

    for (genvar g = 0; g < NDIG; g++) begin : g_dec
        localparam int M = digit_mod(MODE, g);
        bcd_decade #(.MOD(M)) u_dec (
            .cur_q (cnt_q[g*DIGIT_W +: DIGIT_W]),
            .up    (up_dn),
            .en    (chain[g]),
            .ld_raw(load_data),
            .nxt_d (cnt_step[g*DIGIT_W +: DIGIT_W]),
            .ld_val(ld_vals[g*DIGIT_W +: DIGIT_W]),
            .ripple(chain[g+1])
        );
        assign max_val[g*DIGIT_W +: DIGIT_W] = DIGIT_W'(M - 1);

        // R11: every decade stays below its own modulus
        p_digit_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[g*DIGIT_W +: DIGIT_W] < DIGIT_W'(M));
    end

    always_comb begin
        load_hit = ctl_q.armed && scan_step && (int'(scan_digit) < NDIG);
        cnt_d    = cnt_step;
        ctl_d    = ctl_q;

        for (int g = 0; g < NDIG; g++) begin
            if (load_hit && int'(scan_digit) == g)
                cnt_d[g*DIGIT_W +: DIGIT_W] = ld_vals[g*DIGIT_W +: DIGIT_W];
        end

        if (!store) ctl_d.latch = cnt_q;

        if (c_fall)       ctl_d.carry = 1'b0;
        if (chain[NDIG])  ctl_d.carry = 1'b1;

        if (load_req) begin
            ctl_d.armed = 1'b1;
            ctl_d.done  = '0;
        end else if (load_hit) begin
            ctl_d.done[scan_digit] = 1'b1;
            if (&ctl_d.done) ctl_d.armed = 1'b0;
        end

        ctl_d.zero = (cnt_d == '0) && !ctl_d.armed;
    end

    always_ff @(posedge clk or negedge rst_n or posedge clear) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else            cnt_q <= cnt_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign count_bcd = cnt_q;
    assign latch_bcd = ctl_q.latch;
    assign carry     = ctl_q.carry;
    assign zero      = ctl_q.zero;
    assign loading   = ctl_q.armed;

    // R7: carry only rises when the counter sits at a wrap value
    p_carry_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry) |-> (count_bcd == '0 || count_bcd == max_val));

    // R8: zero is never reported over a nonzero count
    p_zero_only_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> (count_bcd == '0));

    // R12: zero is held off while a load is armed
    p_zero_off_while_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> !zero);

    // R4: an inhibited edge leaves the counter alone
    p_inhibit_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rise && inhibit && !loading && !clear) |=> (clear || $stable(count_bcd)));

    // R6: a holding latch does not move
    p_store_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> $stable(latch_bcd));

    // R9: an armed load always has at least one digit left to write
    p_load_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> !(&ctl_q.done));
endmodule

// File: tb/test_bcd_updown_counter6.sv
module test_bcd_updown_counter6;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_in = 1'b0, up_dn = 1'b1, inhibit = 1'b0, clear = 1'b0;
    logic        store = 1'b0, load_req = 1'b0, scan_step = 1'b0;
    logic [2:0]  scan_digit = '0;
    logic [3:0]  load_data = '0;
    logic [23:0] cnt_dec, lat_dec, cnt_tim, lat_tim;
    logic        cy_dec, z_dec, ld_dec, cy_tim, z_tim, ld_tim;

    int checks = 0;
    int failures = 0;

    typedef struct {
        string       tag;
        int          sel;
        logic [23:0] exp;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    bcd_updown_counter6 #(.MODE(0)) i_bcd_updown_counter6 (
        .clk(clk), .rst_n(rst_n), .count_in(count_in), .up_dn(up_dn),
        .inhibit(inhibit), .clear(clear), .store(store), .load_req(load_req),
        .scan_step(scan_step), .scan_digit(scan_digit), .load_data(load_data),
        .count_bcd(cnt_dec), .latch_bcd(lat_dec), .carry(cy_dec),
        .zero(z_dec), .loading(ld_dec));

    bcd_updown_counter6 #(.MODE(2)) i_time (
        .clk(clk), .rst_n(rst_n), .count_in(count_in), .up_dn(up_dn),
        .inhibit(inhibit), .clear(clear), .store(store), .load_req(load_req),
        .scan_step(scan_step), .scan_digit(scan_digit), .load_data(load_data),
        .count_bcd(cnt_tim), .latch_bcd(lat_tim), .carry(cy_tim),
        .zero(z_tim), .loading(ld_tim));

    // sel: 0 decimal count, 1 decimal latch, 2 time count, 3 decimal flags {carry,zero,loading}
    task automatic expect_item(input string tag, input int sel, input logic [23:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb.push_back(it);
    endtask

    // Scoreboard monitor: compares queued expectations shortly after each falling edge
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            logic [23:0] act;
            it = sb.pop_front();
            case (it.sel)
                0: act = cnt_dec;
                1: act = lat_dec;
                2: act = cnt_tim;
                default: act = {21'd0, cy_dec, z_dec, ld_dec};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%06h expected=%06h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic dir, input int n);
        for (int i = 0; i < n; i++) begin
            up_dn = dir; count_in = 1'b1; wait_neg(4);
            count_in = 1'b0; wait_neg(4);
        end
    endtask

    task automatic load_digit(input int idx, input logic [3:0] val);
        scan_digit = 3'(idx); load_data = val; scan_step = 1'b1;
        @(negedge clk);
        scan_step = 1'b0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);
        expect_item("R1 count", 0, 24'h000000);
        expect_item("R1 latch", 1, 24'h000000);
        expect_item("R1 R8 flags", 3, 24'h2);

        pulse(1'b1, 12);
        expect_item("R2 up", 0, 24'h000012);
        expect_item("R2 up time", 2, 24'h000012);
        expect_item("R6 follow", 1, 24'h000012);

        pulse(1'b0, 3);
        expect_item("R3 down", 0, 24'h000009);
        pulse(1'b0, 9);
        expect_item("R8 zero", 3, 24'h2);

        // down from zero: carry in high phase, all-maximum value
        up_dn = 1'b0; count_in = 1'b1; wait_neg(4);
        expect_item("R7 borrow", 3, 24'h4);
        expect_item("R3 wrap", 0, 24'h999999);
        expect_item("R11 max", 2, 24'h595999);
        count_in = 1'b0; wait_neg(4);
        expect_item("R7 fall", 3, 24'h0);

        up_dn = 1'b1; count_in = 1'b1; wait_neg(4);
        expect_item("R7 carry up", 3, 24'h6);
        expect_item("R2 wrap", 0, 24'h000000);
        expect_item("R11 wrap", 2, 24'h000000);
        count_in = 1'b0; wait_neg(4);

        inhibit = 1'b1;
        pulse(1'b1, 3);
        expect_item("R4 inhibit", 0, 24'h000000);
        inhibit = 1'b0;

        pulse(1'b1, 5);
        store = 1'b1;
        pulse(1'b1, 3);
        expect_item("R6 hold", 1, 24'h000005);
        expect_item("R6 count", 0, 24'h000008);

        @(negedge clk);
        #2 clear = 1'b1;
        #1 checks++;
        if (cnt_dec !== 24'h0) begin
            failures++;
            $display("FAIL R5 async actual=%06h expected=000000", cnt_dec);
        end
        @(negedge clk);
        clear = 1'b0;
        expect_item("R5 latch kept", 1, 24'h000005);
        expect_item("R5 cleared", 0, 24'h000000);
        store = 1'b0;
        wait_neg(2);
        expect_item("R6 resume", 1, 24'h000000);

        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        expect_item("R12 armed", 3, 24'h1);
        load_digit(5, 4'd7);
        load_digit(4, 4'd0);
        load_digit(3, 4'd5);
        expect_item("R9 still armed", 3, 24'h1);
        load_digit(2, 4'd9);
        load_digit(1, 4'd9);
        load_digit(0, 4'd9);
        expect_item("R9 done", 3, 24'h0);
        expect_item("R9 value", 0, 24'h705999);
        expect_item("R10 clamp", 2, 24'h005999);

        pulse(1'b1, 1);
        expect_item("R2 ripple", 0, 24'h706000);
        expect_item("R11 six", 2, 24'h010000);

        wait_neg(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule